// File: doc/BRIEF.md
# Variable-Length Instruction Pre-Decoder

This block sits between instruction fetch and the decode stage of a small processor whose instructions are one to five bytes long. Each cycle the fetch side offers a five-byte window taken at the current fetch address. The block looks at the first byte, works out the instruction length from an irregular opcode map, and rearranges the window into a 32-bit normalized word plus an 8-bit extension byte. Opcode bytes are kept big-endian, while 16-bit operands are stored little-endian in memory and get swapped into natural order.

The block keeps the fetch address itself and advances it by the decoded length on every accepted window. A synchronous redirect input loads a new fetch address and discards any instruction held for the consumer. Results sit in a one-entry output register with valid/ready handshakes on both sides, so the block sustains one instruction per cycle. The output slot is a two-state machine. In SLOT_EMPTY, an accept (transition FILL) moves it to SLOT_HOLD. In SLOT_HOLD, a consume with a simultaneous accept (REFILL) stays in SLOT_HOLD, and a consume without an accept (DRAIN) returns to SLOT_EMPTY. From either state a redirect (FLUSH) goes to SLOT_EMPTY.

Top module: `predecode_unit`

## Requirements
- R1: Reset drives `out_valid` low and loads `fetch_pc` from `reset_pc`.
- R2: First bytes 0x00–0x3F, 0x90–0xBF, 0xEB, 0xF6, 0xFE and 0xFF are 1 byte long. For these the word is the first byte zero-extended, and the bytes that follow have no effect on the word.
- R3: In 0x80–0x8F, a first byte whose bits 3:2 equal its bits 1:0 (0x80, 0x85, 0x8A, 0x8F) is a 2-byte immediate move. Its word is byte0 in bits 15:8 and byte1 in bits 7:0. Every other value in 0x81–0x8E is 1 byte long.
- R4: First bytes 0x40–0x7F, 0xD0–0xDB, 0xE0–0xEA and 0xF0–0xF3 are 2 bytes long, with word = {16'h0, byte0, byte1}.
- R5: First bytes 0xC0–0xCF, 0xDC–0xDF, 0xEC–0xEF and 0xF8–0xFD are 3 bytes long, with word = {8'h0, byte0, byte2, byte1}.
- R6: First byte 0xF5 is 3 bytes long, with word = {8'h0, byte0, byte1, byte2}.
- R7: First byte 0xF7 is 4 bytes long, with word = {byte0, byte1, byte3, byte2}.
- R8: First byte 0xF4 is 5 bytes long, with word = {byte0, byte1, byte4, byte3} and extension = byte2. For every other instruction the extension is zero.
- R9: `out_len` reports the decoded length, and `out_pc` is the address the instruction was taken from. Each accepted window advances `fetch_pc` by exactly that length, modulo 2^PC_W.
- R10: `out_illegal` is raised only when no length class matches. Since the map covers all 256 byte values, it never rises.
- R11: `win_ready` is high exactly when the output slot is empty or is being consumed in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and `fetch_pc` does not move.
- R12: `redir_valid` loads `fetch_pc` from `redir_pc` and clears `out_valid` on the next cycle. A window offered in the same cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_pc | input | PC_W | Fetch address loaded by reset |
| redir_valid | input | 1 | Load a new fetch address and flush the slot |
| redir_pc | input | PC_W | New fetch address |
| win_valid | input | 1 | Fetch window is valid |
| win_bytes | input | 40 | Window; byte0 (at fetch_pc) in bits 7:0 |
| win_ready | output | 1 | Window is taken this cycle if valid |
| fetch_pc | output | PC_W | Address at which the next window must start |
| out_valid | output | 1 | Normalized instruction available |
| out_ready | input | 1 | Consumer takes the instruction |
| out_word | output | 32 | Normalized instruction word |
| out_ext | output | 8 | Extension byte (five-byte form only) |
| out_len | output | 3 | Instruction length in bytes |
| out_pc | output | PC_W | Address of the instruction |
| out_illegal | output | 1 | No length class matched |

## Verification
The bench targets the class boundaries: 0x3F against 0x40, 0xDB against 0xDC, 0xEA/0xEB/0xEC, and the separate 0xF4–0xF7 group. A wrong range edge shows up as a wrong length, a skewed fetch address, and a truncated or overlong word. The 0x8x group is checked for equal and unequal register fields, because a missed comparison turns the immediate move into a 1-byte instruction. Filler bytes after every instruction are chosen to expose a packer that leaks unused bytes or forgets the halfword swap. A stall with a pending window, a redirect in the same cycle as a window, and a mid-run reset check that the slot never drops, duplicates or steps the address twice.

// File: rtl/pd_pkg.sv
package pd_pkg;
    localparam int BYTE_W    = 8;
    localparam int WIN_BYTES = 5;
    localparam int WIN_W     = BYTE_W * WIN_BYTES;
    localparam int WORD_W    = 32;
    localparam int LEN_W     = $clog2(WIN_BYTES + 1);

    typedef enum logic [2:0] {
        LC_ONE,
        LC_TWO,
        LC_THREE_SWAP,
        LC_THREE_BIG,
        LC_FOUR,
        LC_FIVE,
        LC_NONE
    } len_class_e;

    typedef enum logic {
        SLOT_EMPTY,
        SLOT_HOLD
    } slot_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [BYTE_W-1:0] ext;
        logic [LEN_W-1:0]  len;
        logic              illegal;
    } pd_result_t;
endpackage

// File: rtl/pd_len_decode.sv
module pd_len_decode
    import pd_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output len_class_e        cls,
    output logic [LEN_W-1:0]  len,
    output logic              illegal
);
    logic imm_move;

    // the immediate-move forms have equal 2-bit register fields
    assign imm_move = (opcode[3:2] == opcode[1:0]);

    always_comb begin
        cls = LC_NONE;
        case (opcode) inside
            [8'h00:8'h3F]: cls = LC_ONE;
            [8'h40:8'h7F]: cls = LC_TWO;
            [8'h80:8'h8F]: cls = imm_move ? LC_TWO : LC_ONE;
            [8'h90:8'hBF]: cls = LC_ONE;
            [8'hC0:8'hCF]: cls = LC_THREE_SWAP;
            [8'hD0:8'hDB]: cls = LC_TWO;
            [8'hDC:8'hDF]: cls = LC_THREE_SWAP;
            [8'hE0:8'hEA]: cls = LC_TWO;
            8'hEB:         cls = LC_ONE;
            [8'hEC:8'hEF]: cls = LC_THREE_SWAP;
            [8'hF0:8'hF3]: cls = LC_TWO;
            8'hF4:         cls = LC_FIVE;
            8'hF5:         cls = LC_THREE_BIG;
            8'hF6:         cls = LC_ONE;
            8'hF7:         cls = LC_FOUR;
            [8'hF8:8'hFD]: cls = LC_THREE_SWAP;
            8'hFE, 8'hFF:  cls = LC_ONE;
            default:       cls = LC_NONE;
        endcase
    end

    always_comb begin
        illegal = 1'b0;
        unique case (cls)
            LC_ONE:        len = LEN_W'(1);
            LC_TWO:        len = LEN_W'(2);
            LC_THREE_SWAP,
            LC_THREE_BIG:  len = LEN_W'(3);
            LC_FOUR:       len = LEN_W'(4);
            LC_FIVE:       len = LEN_W'(5);
            default: begin
                len     = LEN_W'(1);
                illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pd_word_pack.sv
module pd_word_pack
    import pd_pkg::*;
(
    input  logic [WIN_W-1:0]  win,
    input  len_class_e        cls,
    output logic [WORD_W-1:0] word,
    output logic [BYTE_W-1:0] ext
);
    logic [BYTE_W-1:0] b [WIN_BYTES];

    for (genvar gi = 0; gi < WIN_BYTES; gi++) begin : g_unpack
        assign b[gi] = win[gi*BYTE_W +: BYTE_W];
    end

    always_comb begin
        word = '0;
        ext  = '0;
        unique case (cls)
            LC_ONE:        word = {24'h0, b[0]};
            LC_TWO:        word = {16'h0, b[0], b[1]};
            LC_THREE_SWAP: word = {8'h0, b[0], b[2], b[1]};
            LC_THREE_BIG:  word = {8'h0, b[0], b[1], b[2]};
            LC_FOUR:       word = {b[0], b[1], b[3], b[2]};
            LC_FIVE: begin
                word = {b[0], b[1], b[4], b[3]};
                ext  = b[2];
            end
            default:       word = {24'h0, b[0]};
        endcase
    end
endmodule

// File: rtl/pd_pc_track.sv
module pd_pc_track
    import pd_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  reset_pc,
    input  logic             redir_valid,
    input  logic [PC_W-1:0]  redir_pc,
    input  logic             step_en,
    input  logic [LEN_W-1:0] step_len,
    output logic [PC_W-1:0]  pc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc <= reset_pc;
        else if (redir_valid)
            pc <= redir_pc;
        else if (step_en)
            pc <= pc + PC_W'(step_len);
    end
endmodule

// File: rtl/pd_out_stage.sv
module pd_out_stage
    import pd_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            in_valid,
    input  pd_result_t      in_data,
    input  logic [PC_W-1:0] in_pc,
    output logic            in_ready,
    output logic            accept,
    output logic            out_valid,
    input  logic            out_ready,
    output pd_result_t      out_data,
    output logic [PC_W-1:0] out_pc
);
    slot_state_e state, state_nx;

    assign in_ready  = (state == SLOT_EMPTY) || out_ready;
    assign accept    = in_valid && in_ready && !flush;
    assign out_valid = (state == SLOT_HOLD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SLOT_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SLOT_EMPTY: if (accept) state_nx = SLOT_HOLD;                  // FILL
            SLOT_HOLD:  if (out_ready && !accept) state_nx = SLOT_EMPTY;   // DRAIN
            default:    state_nx = SLOT_EMPTY;
        endcase
        if (flush) state_nx = SLOT_EMPTY;                                  // FLUSH
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data <= '0;
            out_pc   <= '0;
        end else if (accept) begin
            out_data <= in_data;
            out_pc   <= in_pc;
        end
    end
endmodule

// File: rtl/predecode_unit.sv
module predecode_unit
    import pd_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PC_W-1:0]    reset_pc,
    input  logic               redir_valid,
    input  logic [PC_W-1:0]    redir_pc,
    input  logic               win_valid,
    input  logic [WIN_W-1:0]   win_bytes,
    output logic               win_ready,
    output logic [PC_W-1:0]    fetch_pc,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_word,
    output logic [BYTE_W-1:0]  out_ext,
    output logic [LEN_W-1:0]   out_len,
    output logic [PC_W-1:0]    out_pc,
    output logic               out_illegal
);
    len_class_e cls;
    pd_result_t cur, held;
    logic       accept;

    pd_len_decode i_len (
        .opcode  (win_bytes[BYTE_W-1:0]),
        .cls     (cls),
        .len     (cur.len),
        .illegal (cur.illegal)
    );

    pd_word_pack i_pack (
        .win  (win_bytes),
        .cls  (cls),
        .word (cur.word),
        .ext  (cur.ext)
    );

    pd_pc_track #(.PC_W(PC_W)) i_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .reset_pc    (reset_pc),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .step_en     (accept),
        .step_len    (cur.len),
        .pc          (fetch_pc)
    );

    pd_out_stage #(.PC_W(PC_W)) i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (redir_valid),
        .in_valid  (win_valid),
        .in_data   (cur),
        .in_pc     (fetch_pc),
        .in_ready  (win_ready),
        .accept    (accept),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (held),
        .out_pc    (out_pc)
    );

    assign out_word    = held.word;
    assign out_ext     = held.ext;
    assign out_len     = held.len;
    assign out_illegal = held.illegal;
endmodule

// File: rtl/pd_checker.sv
module pd_checker
    import pd_pkg::*;
#(
    parameter int PC_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              redir_valid,
    input logic [PC_W-1:0]   redir_pc,
    input logic              win_valid,
    input logic              win_ready,
    input logic [PC_W-1:0]   fetch_pc,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_word,
    input logic [BYTE_W-1:0] out_ext,
    input logic [LEN_W-1:0]  out_len,
    input logic [PC_W-1:0]   out_pc,
    input logic              out_illegal
);
    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !redir_valid |=>
            out_valid && $stable(out_word) && $stable(out_ext) && $stable(out_pc) && $stable(fetch_pc));

    // R11
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !win_ready);

    // R12
    redir_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !out_valid && fetch_pc == $past(redir_pc));

    // R9
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid && win_ready && !redir_valid |=>
            out_valid && fetch_pc == $past(fetch_pc) + PC_W'(out_len) && out_pc == $past(fetch_pc));

    // R10
    no_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_illegal);

    // R8
    ext_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_len != LEN_W'(5) |-> out_ext == '0);
endmodule

bind predecode_unit pd_checker #(.PC_W(PC_W)) i_pd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .win_valid   (win_valid),
    .win_ready   (win_ready),
    .fetch_pc    (fetch_pc),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_word    (out_word),
    .out_ext     (out_ext),
    .out_len     (out_len),
    .out_pc      (out_pc),
    .out_illegal (out_illegal)
);

// File: tb/test_predecode_unit.sv
`timescale 1ns/1ps
module test_predecode_unit;
    localparam int PC_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   reset_pc = 16'h1000;
    logic              redir_valid = 1'b0;
    logic [PC_W-1:0]   redir_pc = '0;
    logic              win_valid = 1'b0;
    logic [39:0]       win_bytes = '0;
    logic              win_ready;
    logic [PC_W-1:0]   fetch_pc;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [31:0]       out_word;
    logic [7:0]        out_ext;
    logic [2:0]        out_len;
    logic [PC_W-1:0]   out_pc;
    logic              out_illegal;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    predecode_unit #(.PC_W(PC_W)) i_predecode_unit (
        .clk(clk), .rst_n(rst_n), .reset_pc(reset_pc),
        .redir_valid(redir_valid), .redir_pc(redir_pc),
        .win_valid(win_valid), .win_bytes(win_bytes), .win_ready(win_ready),
        .fetch_pc(fetch_pc), .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .out_ext(out_ext), .out_len(out_len),
        .out_pc(out_pc), .out_illegal(out_illegal)
    );

    typedef struct packed {
        logic [39:0] win;
        logic [31:0] word;
        logic [7:0]  ext;
        logic [2:0]  len;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{40'hA5A5A5A5_00, 32'h0000_0000, 8'h00, 3'd1},   // R2
        '{40'hA5A5A5A5_3F, 32'h0000_003F, 8'h00, 3'd1},   // R2
        '{40'hC3C3C3C3_9A, 32'h0000_009A, 8'h00, 3'd1},   // R2
        '{40'hC3C3C3C3_EB, 32'h0000_00EB, 8'h00, 3'd1},   // R2
        '{40'hC3C3C3C3_F6, 32'h0000_00F6, 8'h00, 3'd1},   // R2
        '{40'hC3C3C3C3_FE, 32'h0000_00FE, 8'h00, 3'd1},   // R2
        '{40'hC3C3C3C3_FF, 32'h0000_00FF, 8'h00, 3'd1},   // R2
        '{40'h5A5A5A7F_80, 32'h0000_807F, 8'h00, 3'd2},   // R3
        '{40'h5A5A5A12_85, 32'h0000_8512, 8'h00, 3'd2},   // R3
        '{40'h5A5A5A34_8A, 32'h0000_8A34, 8'h00, 3'd2},   // R3
        '{40'h5A5A5A56_8F, 32'h0000_8F56, 8'h00, 3'd2},   // R3
        '{40'h5A5A5AAA_81, 32'h0000_0081, 8'h00, 3'd1},   // R3
        '{40'h5A5A5AAA_8E, 32'h0000_008E, 8'h00, 3'd1},   // R3
        '{40'h5A5A5AAA_84, 32'h0000_0084, 8'h00, 3'd1},   // R3
        '{40'hE7E7E75A_40, 32'h0000_405A, 8'h00, 3'd2},   // R4
        '{40'hE7E7E7C4_7F, 32'h0000_7FC4, 8'h00, 3'd2},   // R4
        '{40'hE7E7E701_DB, 32'h0000_DB01, 8'h00, 3'd2},   // R4
        '{40'hE7E7E7EE_EA, 32'h0000_EAEE, 8'h00, 3'd2},   // R4
        '{40'hE7E7E799_F3, 32'h0000_F399, 8'h00, 3'd2},   // R4
        '{40'h9C9C1234_C0, 32'h00C0_1234, 8'h00, 3'd3},   // R5
        '{40'h9C9CCDAB_DC, 32'h00DC_CDAB, 8'h00, 3'd3},   // R5
        '{40'h9C9C0201_EF, 32'h00EF_0201, 8'h00, 3'd3},   // R5
        '{40'h9C9CFF00_F8, 32'h00F8_FF00, 8'h00, 3'd3},   // R5
        '{40'h6B6BB2A1_F5, 32'h00F5_A1B2, 8'h00, 3'd3},   // R6
        '{40'h6B332211_F7, 32'hF711_3322, 8'h00, 3'd4},   // R7
        '{40'h04030201_F4, 32'hF401_0403, 8'h02, 3'd5},   // R8
        '{40'hDDCCBBAA_F4, 32'hF4AA_DDCC, 8'hBB, 3'd5}    // R8
    };

    function automatic int ref_len(input logic [7:0] op);
        if (op <= 8'h3F) return 1;
        if (op <= 8'h7F) return 2;
        if (op <= 8'h8F) return (op[3:2] == op[1:0]) ? 2 : 1;
        if (op <= 8'hBF) return 1;
        if (op <= 8'hCF) return 3;
        if (op <= 8'hDB) return 2;
        if (op <= 8'hDF) return 3;
        if (op <= 8'hEA) return 2;
        if (op == 8'hEB) return 1;
        if (op <= 8'hEF) return 3;
        if (op <= 8'hF3) return 2;
        if (op == 8'hF4) return 5;
        if (op == 8'hF5) return 3;
        if (op == 8'hF6) return 1;
        if (op == 8'hF7) return 4;
        if (op <= 8'hFD) return 3;
        return 1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [PC_W-1:0] pc_model;
        logic [31:0]     hold_word;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
        check(fetch_pc == 16'h1000, "R1 fetch_pc in reset", 64'(fetch_pc), 64'h1000);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
        check(win_ready == 1'b1, "R11 ready when empty", 64'(win_ready), 64'd1);
        pc_model = 16'h1000;

        // table walk: R2..R9
        for (int i = 0; i < NV; i++) begin
            win_valid = 1'b1;
            win_bytes = VECS[i].win;
            @(negedge clk);
            check(out_valid == 1'b1, $sformatf("R9 vec %0d valid", i), 64'(out_valid), 64'd1);
            check(out_word == VECS[i].word, $sformatf("R2..R8 vec %0d word", i), 64'(out_word), 64'(VECS[i].word));
            check(out_ext == VECS[i].ext, $sformatf("R8 vec %0d ext", i), 64'(out_ext), 64'(VECS[i].ext));
            check(out_len == VECS[i].len, $sformatf("R9 vec %0d len", i), 64'(out_len), 64'(VECS[i].len));
            check(out_pc == pc_model, $sformatf("R9 vec %0d out_pc", i), 64'(out_pc), 64'(pc_model));
            pc_model = pc_model + PC_W'(VECS[i].len);
            check(fetch_pc == pc_model, $sformatf("R9 vec %0d fetch_pc", i), 64'(fetch_pc), 64'(pc_model));
        end

        // R10: sweep every first-byte value
        for (int op = 0; op < 256; op++) begin
            win_bytes = {32'h55667788, 8'(op)};
            @(negedge clk);
            check(out_illegal == 1'b0, $sformatf("R10 illegal op %0h", op), 64'(out_illegal), 64'd0);
            check(out_len == 3'(ref_len(8'(op))), $sformatf("R9 len op %0h", op), 64'(out_len), 64'(ref_len(8'(op))));
            pc_model = pc_model + PC_W'(ref_len(8'(op)));
        end
        check(fetch_pc == pc_model, "R9 fetch_pc after sweep", 64'(fetch_pc), 64'(pc_model));

        // R11: drain without a new window
        win_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R11 drain empties slot", 64'(out_valid), 64'd0);

        // R11: stall holds output, pending window not taken
        out_ready = 1'b0;
        win_valid = 1'b1;
        win_bytes = 40'h6B332211_F7;
        @(negedge clk);
        hold_word = out_word;
        check(out_word == 32'hF7113322, "R11 captured before stall", 64'(out_word), 64'hF7113322);
        check(win_ready == 1'b0, "R11 ready low when held", 64'(win_ready), 64'd0);
        pc_model = pc_model + 16'd4;
        win_bytes = 40'hA5A5A5A5_3F;
        repeat (2) @(negedge clk);
        check(out_valid && out_word == hold_word, "R11 output held", 64'(out_word), 64'(hold_word));
        check(fetch_pc == pc_model, "R11 fetch_pc frozen", 64'(fetch_pc), 64'(pc_model));
        out_ready = 1'b1;
        #1;
        check(win_ready == 1'b1, "R11 ready with consume", 64'(win_ready), 64'd1);
        @(negedge clk);
        check(out_word == 32'h3F, "R11 refill word", 64'(out_word), 64'h3F);
        check(out_pc == pc_model, "R11 refill pc", 64'(out_pc), 64'(pc_model));

        // R12: redirect while held, with a window offered the same cycle
        out_ready = 1'b0;
        redir_valid = 1'b1;
        redir_pc = 16'h2345;
        win_bytes = 40'h04030201_F4;
        @(negedge clk);
        redir_valid = 1'b0;
        check(out_valid == 1'b0, "R12 flush clears valid", 64'(out_valid), 64'd0);
        check(fetch_pc == 16'h2345, "R12 fetch_pc loaded", 64'(fetch_pc), 64'h2345);
        out_ready = 1'b1;
        @(negedge clk);
        check(out_pc == 16'h2345 && out_ext == 8'h02, "R12 first after redirect", 64'(out_pc), 64'h2345);
        check(fetch_pc == 16'h234A, "R12 step after redirect", 64'(fetch_pc), 64'h234A);
        win_valid = 1'b0;

        // R1: mid-run reset with a new vector
        reset_pc = 16'h0ABC;
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 mid-run reset valid", 64'(out_valid), 64'd0);
        check(fetch_pc == 16'h0ABC, "R1 mid-run reset pc", 64'(fetch_pc), 64'h0ABC);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule